// File: doc/BRIEF.md
# Six-State External Memory Bus Sequencer

This block is the master side of a byte-wide external memory bus of the kind found on small microcontrollers. A core hands it one request at a time: a code fetch, a data read or a data write. The sequencer turns that request into pin activity. A shared 8-bit port carries first the low address byte and then the data. A second 8-bit port carries the high address byte. The strobes are an address latch enable (high active), a program-store enable, a read strobe and a write strobe (all low active). The port is modelled as separate out, output-enable and in buses, so the pad ring builds the tristate.

Timing is counted in phases of the input clock. A machine cycle has six states, and each state lasts `CLKS_PER_STATE` clocks, which is 2 by default. A fetch occupies one machine cycle, 12 phases, numbered 0 to 11. It presents the requested address in the first half and the next address in the second half. A data access occupies two machine cycles, 24 phases, numbered 0 to 23. The phase counts in the requirements assume the default of 2 clocks per state.

Requests use a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle. A request is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. The sequencer then holds `cmd_ready` low until it has finished the access. That is the only back-pressure on the request side. Returned bytes come out as a one-clock `rsp_valid` pulse with `rsp_data`. The response path has no ready signal, so the consumer must take each byte in the clock it appears.

Top module: `xbus_seq`

## Requirements
- R1: After reset, and at all times while idle, the bus is quiet: `ale` is low, `psen_n`, `rd_n` and `wr_n` are high, `p0_oe` is low, `cmd_ready` is high and `rsp_valid` is low.
- R2: A request accepted on clock edge E has phase 0 in the clock after E. `cmd_ready` stays low for 12 clocks for a fetch and 24 clocks for a data access. It is high again in the next clock.
- R3: In a fetch, `ale` is high in phases 0, 1, 6 and 7. `p0_oe` is high with the low address byte on `p0_out` in phases 0 to 2 and 6 to 8. Phases 0 to 5 present the request address, and phases 6 to 11 present the request address plus one, with the carry taken into the high byte. `p2_out` carries the high byte of the presented address.
- R4: In a fetch, `psen_n` is low in phases 3 to 5 and 9 to 11. `rd_n` and `wr_n` stay high.
- R5: In a fetch, `p0_in` is sampled in phases 5 and 11. The byte from phase 5 is returned as a `rsp_valid` pulse in the following clock. The byte from phase 11 is returned the same way only when `cmd_two` was set with the request.
- R6: In a data access, `ale` is high only in phases 6 and 7, with the data address low byte on `p0_out` in phases 6 to 8. `ale` stays low for the whole second machine cycle. `psen_n` stays high throughout, and `p2_out` carries the address high byte.
- R7: In a data read, `rd_n` is low in phases 12 to 20 while `p0_oe` is low. `p0_in` is sampled in phase 20 and returned with a `rsp_valid` pulse in the next clock.
- R8: In a data write, `wr_n` is low in phases 12 to 20. `p0_oe` is high with `cmd_wdata` on `p0_out` during exactly those phases. No response is returned.
- R9: `cmd_op` encoding: 2'b00 is a fetch, 2'b01 is a data read, 2'b10 is a data write, and 2'b11 behaves exactly as 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Sequencer idle, request can be taken |
| cmd_op | input | 2 | Request kind (see R9) |
| cmd_two | input | 1 | Fetch returns a second byte from address plus one |
| cmd_addr | input | 16 | Request address |
| cmd_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-clock pulse with a returned byte |
| rsp_data | output | 8 | Returned byte |
| ale | output | 1 | Address latch enable, high active |
| psen_n | output | 1 | Program-store enable, low active |
| rd_n | output | 1 | Data read strobe, low active |
| wr_n | output | 1 | Data write strobe, low active |
| p0_out | output | 8 | Shared port: low address byte or write data |
| p0_oe | output | 1 | Shared port output enable |
| p0_in | input | 8 | Shared port input data |
| p2_out | output | 8 | High address byte port |

## Verification
The hardest case to reach from the ports is the second fetch byte when the address crosses a 256-byte boundary. In that case the high port must change in the middle of a machine cycle, and the returned byte must come from the incremented address. The bench drives `p0_in` from a memory model. The model latches the address it actually sees on the ports. A wrong carry, a wrong sampling phase or a wrong address therefore all show up as a data mismatch. Directed requests at 0x00FF and 0xFFFF sit on those boundaries. A seeded random mix of all four op codes covers back-to-back accesses of different lengths.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2
  } kind_e;

  // Request op decode; the spare code falls back to a fetch.
  function automatic kind_e decode_op(input logic [1:0] op);
    case (op)
      2'b01:   return K_READ;
      2'b10:   return K_WRITE;
      default: return K_FETCH;
    endcase
  endfunction

endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CYC    = 12,
  parameter int PH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_two,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic [PH_W-1:0]   ph,
  output kind_e             kind,
  output logic              two,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);

  localparam logic [PH_W-1:0] LAST_FETCH = PH_W'(CYC - 1);
  localparam logic [PH_W-1:0] LAST_DATA  = PH_W'(2 * CYC - 1);

  logic [PH_W-1:0] last;

  assign last      = (kind == K_FETCH) ? LAST_FETCH : LAST_DATA;
  assign cmd_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ph    <= '0;
      kind  <= K_FETCH;
      two   <= 1'b0;
      addr  <= '0;
      wdata <= '0;
    end else if (!busy) begin
      if (cmd_valid) begin
        busy  <= 1'b1;
        ph    <= '0;
        kind  <= decode_op(cmd_op);
        two   <= cmd_two;
        addr  <= cmd_addr;
        wdata <= cmd_wdata;
      end
    end else if (ph == last) begin
      busy <= 1'b0;
    end else begin
      ph <= ph + PH_W'(1);
    end
  end

endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
  import xbus_pkg::*;
#(
  parameter int CLKS = 2,
  parameter int CYC  = 12,
  parameter int PH_W = 5
) (
  input  logic            busy,
  input  logic [PH_W-1:0] ph,
  input  kind_e           kind,
  input  logic            two,
  output logic            ale,
  output logic            psen_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic            addr_drv,
  output logic            data_drv,
  output logic            sample,
  output logic            half2
);

  // A fetch machine cycle splits into two byte slots of three states each.
  localparam int HALF      = 3 * CLKS;
  // Data strobe runs from S1 of the second cycle through the first clock of S5.
  localparam int STROBE_HI = CYC + 4 * CLKS;

  int p;
  int pos;
  logic strobe;

  always_comb begin
    p        = int'(ph);
    pos      = (p >= HALF) ? p - HALF : p;
    half2    = 1'b0;
    ale      = 1'b0;
    psen_n   = 1'b1;
    rd_n     = 1'b1;
    wr_n     = 1'b1;
    addr_drv = 1'b0;
    data_drv = 1'b0;
    sample   = 1'b0;
    strobe   = 1'b0;
    if (busy) begin
      if (kind == K_FETCH) begin
        half2    = (p >= HALF);
        ale      = (pos < CLKS);
        addr_drv = (pos <= CLKS);
        psen_n   = !(pos > CLKS);
        sample   = (pos == HALF - 1) && (!half2 || two);
      end else begin
        ale      = (p >= HALF) && (p < HALF + CLKS);
        addr_drv = (p >= HALF) && (p <= HALF + CLKS);
        strobe   = (p >= CYC) && (p <= STROBE_HI);
        rd_n     = !(strobe && kind == K_READ);
        wr_n     = !(strobe && kind == K_WRITE);
        data_drv = strobe && (kind == K_WRITE);
        sample   = (kind == K_READ) && (p == STROBE_HI);
      end
    end
  end

endmodule

// File: rtl/xbus_capture.sv
module xbus_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [DATA_W-1:0] p0_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= sample;
      if (sample) rsp_data <= p0_in;
    end
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 8,
  parameter int CLKS_PER_STATE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [1:0]               cmd_op,
  input  logic                     cmd_two,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [DATA_W-1:0]        cmd_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        p0_out,
  output logic                     p0_oe,
  input  logic [DATA_W-1:0]        p0_in,
  output logic [ADDR_W-DATA_W-1:0] p2_out
);

  localparam int STATES = 6;
  localparam int CYC    = STATES * CLKS_PER_STATE;
  localparam int PH_W   = $clog2(2 * CYC);

  logic              busy;
  logic [PH_W-1:0]   ph;
  kind_e             kind;
  logic              two;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic              addr_drv;
  logic              data_drv;
  logic              sample;
  logic              half2;
  logic [ADDR_W-1:0] cur_addr;

  xbus_phase_ctr #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC(CYC), .PH_W(PH_W)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_two(cmd_two),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .ph(ph), .kind(kind), .two(two),
    .addr(addr), .wdata(wdata)
  );

  xbus_strobe_dec #(
    .CLKS(CLKS_PER_STATE), .CYC(CYC), .PH_W(PH_W)
  ) u_dec (
    .busy(busy), .ph(ph), .kind(kind), .two(two),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr_drv(addr_drv), .data_drv(data_drv),
    .sample(sample), .half2(half2)
  );

  xbus_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .sample(sample), .p0_in(p0_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // Second fetch slot presents the following byte address.
  assign cur_addr = half2 ? addr + ADDR_W'(1) : addr;
  assign p0_oe    = addr_drv || data_drv;
  assign p0_out   = data_drv ? wdata : cur_addr[DATA_W-1:0];
  assign p2_out   = cur_addr[ADDR_W-1:DATA_W];

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_valid,
  input logic                     cmd_ready,
  input logic                     rsp_valid,
  input logic                     ale,
  input logic                     psen_n,
  input logic                     rd_n,
  input logic                     wr_n,
  input logic                     p0_oe,
  input logic [ADDR_W-DATA_W-1:0] p2_out
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!ale && psen_n && rd_n && wr_n && !p0_oe));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_ale_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> p0_oe);

  p_ale_psen_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && !psen_n));

  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);

  p_rd_floats_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !p0_oe);

  p_wr_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> p0_oe);

  p_hi_stable_in_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n)) |-> $stable(p2_out));

endmodule

bind xbus_seq xbus_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_xbus_seq.sv
module sim_xbus_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic        cmd_two = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        ale, psen_n, rd_n, wr_n, p0_oe;
  logic [7:0]  p0_out, p0_in, p2_out;
  logic [7:0]  lat = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xbus_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_two(cmd_two),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // External memory model: latches the low address off the shared port.
  always @(negedge clk) if (ale && p0_oe) lat <= p0_out;
  always_comb p0_in = (!psen_n || !rd_n) ? mem_byte({p2_out, lat}) : 8'hEE;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one request; called just after a falling edge.
  task automatic run(input logic [1:0] op, input logic two, input logic [15:0] a,
                     input logic [7:0] wd);
    bit fetch, rd, wr;
    int last;
    string tag;
    fetch = (op == 2'b00) || (op == 2'b11);
    rd    = (op == 2'b01);
    wr    = (op == 2'b10);
    last  = fetch ? 11 : 23;
    tag   = (op == 2'b11) ? " R9" : "";
    cmd_valid = 1'b1; cmd_op = op; cmd_two = two; cmd_addr = a; cmd_wdata = wd;
    for (int k = 0; k <= last + 1; k++) begin
      logic [5:0]  ev, av;
      logic [15:0] ca;
      logic        e_rsp;
      logic [7:0]  e_dat;
      bit          busy;
      int          pos;
      @(negedge clk);
      if (k == 0) cmd_valid = 1'b0;
      busy  = (k <= last);
      pos   = (k >= 6) ? k - 6 : k;
      ca    = (fetch && k >= 6) ? a + 16'd1 : a;
      ev    = 6'b011100;
      e_rsp = 1'b0;
      e_dat = 8'h00;
      if (!busy) ev[0] = 1'b1;
      else if (fetch) begin
        ev[5] = (pos < 2);
        ev[4] = !(pos >= 3);
        ev[1] = (pos <= 2);
      end else begin
        ev[5] = (k == 6 || k == 7);
        ev[3] = !(rd && k >= 12 && k <= 20);
        ev[2] = !(wr && k >= 12 && k <= 20);
        ev[1] = (k >= 6 && k <= 8) || (wr && k >= 12 && k <= 20);
      end
      if (fetch && k == 6) begin e_rsp = 1'b1; e_dat = mem_byte(a); end
      if (fetch && two && k == 12) begin e_rsp = 1'b1; e_dat = mem_byte(a + 16'd1); end
      if (rd && k == 21) begin e_rsp = 1'b1; e_dat = mem_byte(a); end
      av = {ale, psen_n, rd_n, wr_n, p0_oe, cmd_ready};
      chk(av == ev, fetch ? {"R2 R3 R4 fetch strobes", tag} : "R2 R6 R7 R8 data strobes",
          32'(av), 32'(ev));
      if (busy && p0_oe && ev[1]) begin
        if (wr && k >= 12)
          chk(p0_out == wd, "R8 write data on port", 32'(p0_out), 32'(wd));
        else
          chk(p0_out == ca[7:0], fetch ? "R3 low address" : "R6 low address",
              32'(p0_out), 32'(ca[7:0]));
      end
      if (busy && (ev[5] || !ev[4] || !ev[3]))
        chk(p2_out == ca[15:8], fetch ? "R3 high address" : "R6 high address",
            32'(p2_out), 32'(ca[15:8]));
      chk(rsp_valid == e_rsp, fetch ? "R5 response pulse" : (rd ? "R7 response pulse" : "R8 no response"),
          32'(rsp_valid), 32'(e_rsp));
      if (e_rsp)
        chk(rsp_data == e_dat, fetch ? "R5 fetched byte" : "R7 read byte",
            32'(rsp_data), 32'(e_dat));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: quiet bus under reset
    chk({ale, psen_n, rd_n, wr_n, p0_oe, cmd_ready, rsp_valid} == 7'b0111010,
        "R1 reset state", 32'({ale, psen_n, rd_n, wr_n, p0_oe, cmd_ready, rsp_valid}),
        32'(7'b0111010));
    rst_n = 1'b1;
    @(negedge clk);
    chk({ale, psen_n, rd_n, wr_n, p0_oe, cmd_ready, rsp_valid} == 7'b0111010,
        "R1 idle after reset", 32'({ale, psen_n, rd_n, wr_n, p0_oe, cmd_ready, rsp_valid}),
        32'(7'b0111010));
    // Directed corners: carry across a page, wrap at the top, spare op code
    run(2'b00, 1'b1, 16'h00FF, 8'h00);
    run(2'b00, 1'b1, 16'hFFFF, 8'h00);
    run(2'b00, 1'b0, 16'h1234, 8'h00);
    run(2'b11, 1'b1, 16'h12FF, 8'h00);
    run(2'b01, 1'b0, 16'hABCD, 8'h00);
    run(2'b10, 1'b0, 16'h0F0F, 8'hA5);
    run(2'b10, 1'b1, 16'hFFFF, 8'h3C);
    for (int n = 0; n < 60; n++) begin
      logic [1:0]  op;
      logic        tw;
      logic [15:0] ad;
      logic [7:0]  wd;
      op = 2'($urandom_range(0, 3));
      tw = 1'($urandom_range(0, 1));
      ad = 16'($urandom());
      wd = 8'($urandom());
      run(op, tw, ad, wd);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule